// File: doc/BRIEF.md
# One-Bit Serial Microcontroller Core

This block is a tiny processor that works on single bits. It has three one-bit working registers (r0, r1, r2), two input pins and two registered output pins. Its program store holds sixteen 8-bit instruction words, and a 4-bit instruction address selects the current word. No incrementer exists. Each word names its own successor. A conditional jump is formed by replacing the lowest bit of that successor with r0 or r1.

Execution runs in a single clock domain. An internal phase bit alternates between an execute cycle and a commit cycle. In the execute cycle the instruction updates registers and pins, and the successor address goes into a holding register. In the commit cycle that holding register is copied into the instruction address. A halt instruction stops stepping until a rising edge arrives on the wake input. The program store is filled through a write port, and that port only has an effect while reset is asserted.

Top module: `bitseq_core`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears pin_out to 0, clears halted and r0, r1, r2, sets the instruction address and holding register to 0, and selects the execute phase. After reset is released, execution starts at word 0.
- R2: An instruction word has the opcode in bits [2:0], a parameter bit p in bit [3] and the successor address in bits [7:4]. The opcode values are 0 AND, 1 XOR, 2 LD, 3 IN, 4 OUT, 5 COND, 6 MOV, 7 HALT.
- R3: AND sets r2 to r0 AND r1. XOR sets r2 to r0 XOR r1.
- R4: LD sets r2 to p. IN sets r2 to pin_in[p].
- R5: OUT writes r2 into pin_out[p]. The other output bit keeps its value.
- R6: MOV copies r2 into r0 when p is 0, and into r1 when p is 1.
- R7: COND continues at an address made of successor bits [7:5] as the upper bits, with r0 (p=0) or r1 (p=1) as bit 0.
- R8: Each instruction takes two cycles. Its effects appear one cycle after its execute cycle. Outputs never change in a commit cycle.
- R9: HALT raises halted one cycle after its execute cycle and freezes all state. A rising edge on wake clears halted, and execution then continues at the HALT word's successor address.
- R10: A rising edge on wake while the core is running has no effect. A wake level that is held high without a new rising edge does not end a halt.
- R11: Writes through the program port (pgm_we, pgm_addr, pgm_data) take effect only while rst is high. They are ignored while the core runs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; program writes allowed only while high |
| pgm_we | input | 1 | Program store write enable |
| pgm_addr | input | 4 | Program store write address |
| pgm_data | input | 8 | Program store write data |
| pin_in | input | 2 | Input pins read by IN |
| wake | input | 1 | Wake request, rising-edge sensitive |
| pin_out | output | 2 | Registered output pins written by OUT |
| halted | output | 1 | High while execution is stopped by HALT |

## Verification
The assertions check the sequencing rules on every cycle:
- the phase alternates;
- the holding register is copied into the instruction address in the commit cycle;
- outputs stay still outside execute cycles;
- a halted core stays frozen until a wake edge;
- reset reaches its defined state.

The opcode behaviour (the ALU results, pin reads, branch bit substitution and MOV targets) can only be seen through whole programs. So can the fact that writes made while running are ignored. The bench covers these by running random and directed programs against its own instruction-level model.

// File: rtl/bitseq_core.sv
module bitseq_core #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pgm_we,
  input  logic [AW-1:0] pgm_addr,
  input  logic [AW+3:0] pgm_data,
  input  logic [1:0]    pin_in,
  input  logic          wake,
  output logic [1:0]    pin_out,
  output logic          halted
);
  localparam int IW    = AW + 4;
  localparam int DEPTH = 1 << AW;

  typedef enum logic [2:0] {
    OP_AND, OP_XOR, OP_LD, OP_IN, OP_OUT, OP_COND, OP_MOV, OP_HALT
  } op_e;

  logic [IW-1:0] mem [DEPTH];
  logic [AW-1:0] ip, tmp, succ, next_addr;
  logic [IW-1:0] ins;
  logic          r0, r1, r2, phase, wake_q;
  logic          prm, sel_bit, step_a, step_b, wake_edge, r2_new;
  op_e           op;

  assign ins       = mem[ip];
  assign op        = op_e'(ins[2:0]);
  assign prm       = ins[3];
  assign succ      = ins[IW-1:4];
  assign sel_bit   = prm ? r1 : r0;
  assign next_addr = (op == OP_COND) ? {succ[AW-1:1], sel_bit} : succ;
  assign step_a    = !halted && !phase;
  assign step_b    = !halted && phase;
  assign wake_edge = wake && !wake_q;

  always_comb begin
    case (op)
      OP_AND:  r2_new = r0 & r1;
      OP_XOR:  r2_new = r0 ^ r1;
      OP_LD:   r2_new = prm;
      OP_IN:   r2_new = pin_in[prm];
      default: r2_new = r2;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst && pgm_we) mem[pgm_addr] <= pgm_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ip      <= '0;
      tmp     <= '0;
      r0      <= 1'b0;
      r1      <= 1'b0;
      r2      <= 1'b0;
      pin_out <= 2'b00;
      halted  <= 1'b0;
      phase   <= 1'b0;
      wake_q  <= 1'b0;
    end else begin
      wake_q <= wake;
      if (halted) begin
        if (wake_edge) halted <= 1'b0;
      end else if (step_a) begin
        r2    <= r2_new;
        tmp   <= next_addr;
        phase <= 1'b1;
        if (op == OP_OUT) pin_out[prm] <= r2;
        if (op == OP_MOV && !prm) r0 <= r2;
        if (op == OP_MOV && prm)  r1 <= r2;
        if (op == OP_HALT) halted <= 1'b1;
      end else if (step_b) begin
        ip    <= tmp;
        phase <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bitseq_core_chk.sv
module bitseq_core_chk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          wake,
  input logic          wake_q,
  input logic          halted,
  input logic          phase,
  input logic [AW-1:0] ip,
  input logic [AW-1:0] tmp,
  input logic [1:0]    pin_out
);
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (ip == '0 && tmp == '0 && !phase && !halted && pin_out == 2'b00));

  p_phase_alt_r8: assert property (@(posedge clk) disable iff (rst)
    (!halted && !phase) |=> phase);

  p_commit_r8: assert property (@(posedge clk) disable iff (rst)
    (!halted && phase) |=> (!phase && ip == $past(tmp)));

  p_out_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (phase || halted) |=> $stable(pin_out));

  p_halt_freeze_r9: assert property (@(posedge clk) disable iff (rst)
    halted |=> ($stable(ip) && $stable(tmp) && $stable(pin_out) && $stable(phase)));

  p_no_wake_no_resume_r10: assert property (@(posedge clk) disable iff (rst)
    (halted && !(wake && !wake_q)) |=> halted);

  p_halt_only_in_exec_r10: assert property (@(posedge clk) disable iff (rst)
    (!halted && phase) |=> !halted);
endmodule

bind bitseq_core bitseq_core_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .wake(wake), .wake_q(wake_q), .halted(halted),
  .phase(phase), .ip(ip), .tmp(tmp), .pin_out(pin_out)
);

// File: tb/tb_bitseq_core.sv
module tb_bitseq_core;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pgm_we = 1'b0;
  logic [3:0] pgm_addr = '0;
  logic [7:0] pgm_data = '0;
  logic [1:0] pin_in = '0;
  logic       wake = 1'b0;
  logic [1:0] pin_out;
  logic       halted;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] m_mem [16];
  logic [3:0] m_ip, m_tmp;
  logic       m_r0, m_r1, m_r2, m_halt, m_ph, m_wq;
  logic [1:0] m_out;
  string      tag;

  bitseq_core dut (
    .clk(clk), .rst(rst), .pgm_we(pgm_we), .pgm_addr(pgm_addr),
    .pgm_data(pgm_data), .pin_in(pin_in), .wake(wake),
    .pin_out(pin_out), .halted(halted)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic string op_tag(input logic [2:0] op);
    case (op)
      3'd0, 3'd1: return "R3 (R2)";
      3'd2, 3'd3: return "R4 (R2)";
      3'd4:       return "R5 (R2)";
      3'd5:       return "R7 (R2)";
      3'd6:       return "R6 (R2)";
      default:    return "R9 (R2)";
    endcase
  endfunction

  task automatic model_step();
    logic [7:0] w;
    logic [3:0] nf;
    logic       p;
    if (rst) begin
      if (pgm_we) m_mem[pgm_addr] = pgm_data;
      m_ip = 0; m_tmp = 0; m_r0 = 0; m_r1 = 0; m_r2 = 0;
      m_out = 0; m_halt = 0; m_ph = 0; m_wq = 0;
      tag = "R1";
    end else begin
      tag = "R8";
      if (pgm_we) tag = "R11";
      if (m_halt) begin
        tag = "R9";
        if (wake && !m_wq) m_halt = 0;
        else tag = "R10";
      end else if (!m_ph) begin
        if (wake && !m_wq) tag = "R10";
        w = m_mem[m_ip]; p = w[3]; nf = w[7:4];
        if (tag == "R8") tag = op_tag(w[2:0]);
        case (w[2:0])
          3'd0: m_r2 = m_r0 & m_r1;
          3'd1: m_r2 = m_r0 ^ m_r1;
          3'd2: m_r2 = p;
          3'd3: m_r2 = pin_in[p];
          3'd4: m_out[p] = m_r2;
          3'd5: nf = {nf[3:1], p ? m_r1 : m_r0};
          3'd6: if (p) m_r1 = m_r2; else m_r0 = m_r2;
          default: m_halt = 1;
        endcase
        m_tmp = nf; m_ph = 1;
      end else begin
        m_ip = m_tmp; m_ph = 0;
      end
      m_wq = wake;
    end
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    check(pin_out == m_out, tag, pin_out, m_out);
    check(halted == m_halt, tag, halted, m_halt);
  endtask

  task automatic load(input logic [7:0] prog [16]);
    rst = 1;
    for (int i = 0; i < 16; i++) begin
      pgm_we = 1; pgm_addr = 4'(i); pgm_data = prog[i];
      tick();
    end
    pgm_we = 0;
    tick();
    check(pin_out == 2'b00, "R1", pin_out, 0);
    check(halted == 1'b0, "R1", halted, 0);
    rst = 0;
  endtask

  initial begin
    logic [7:0] prog [16];
    void'($urandom(32'd2610));
    @(negedge clk);

    for (int i = 0; i < 16; i++) prog[i] = 8'h07;
    prog[0] = 8'h1A; prog[1] = 8'h26; prog[2] = 8'h32; prog[3] = 8'h4E;
    prog[4] = 8'h85; prog[8] = 8'h87; prog[9] = 8'hAA; prog[10] = 8'hBC;
    prog[11] = 8'hC7; prog[12] = 8'hD4; prog[13] = 8'h07;
    load(prog);
    wake = 1;
    for (int i = 0; i < 40; i++) begin
      pgm_we = (i == 3); pgm_addr = 4'd12; pgm_data = 8'h07;
      tick();
    end
    pgm_we = 0;
    check(pin_out == 2'b10, "R7", pin_out, 2);
    check(halted == 1'b1, "R10", halted, 1);
    wake = 0; tick();
    wake = 1; tick();
    check(halted == 1'b0, "R9", halted, 0);
    wake = 0;
    for (int i = 0; i < 20; i++) tick();
    check(pin_out == 2'b11, "R11", pin_out, 3);
    check(halted == 1'b1, "R9", halted, 1);

    for (int n = 0; n < 25; n++) begin
      for (int i = 0; i < 16; i++) prog[i] = 8'($urandom);
      load(prog);
      for (int c = 0; c < 1500; c++) begin
        pin_in = 2'($urandom);
        if ($urandom_range(0, 7) == 0) wake = ~wake;
        pgm_we = ($urandom_range(0, 15) == 0);
        pgm_addr = 4'($urandom);
        pgm_data = 8'($urandom);
        tick();
      end
      pgm_we = 0;
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule